// File: doc/BRIEF.md
# Permutation-Preserving Single-Point Crossover

This block merges two parent tours into one child tour for a genetic search over city orderings. Each parent is a permutation of the city indices `0 .. N_CITIES-1`. A tour is packed into one vector: slot `i` (the i-th city visited) occupies bits `[i*IDX_W +: IDX_W]`. The child takes the leading slots, up to the cut point, from parent A. The remaining slots are then filled by walking parent B from its slot 0 and appending every city the child does not yet hold. Because the tail is rebuilt this way instead of being copied slot by slot, the child is always a valid tour.

A caller decides outside the block whether crossover applies (the `xo_en` bit) and picks the cut point. It then pulses `start`. The block takes a snapshot of its inputs and runs a short state machine. The states are IDLE, HEAD, SCAN and PUBLISH:

- **IDLE → HEAD** on `start`. The inputs are captured and the used-city mask is cleared.
- **HEAD → PUBLISH** when crossover is disabled or the cut covers every slot. Otherwise **HEAD → SCAN**. In HEAD, the whole of parent A is loaded into the work tour and the mask is preset with the cities placed ahead of the cut.
- **SCAN → SCAN** while parent B still has slots to examine, taking one slot per cycle. **SCAN → PUBLISH** on the last slot of parent B or when the last child slot is written.
- **PUBLISH → IDLE** always. On this transition the registered child output is updated and `done` pulses.

Top module: `pxo_crossover`

## Requirements
- R1: After reset, `child` is all zeros and `done` is 0.
- R2: When `xo_en` is 1, child slots 0 to k-1 equal the same slots of parent A, where k is `cut` limited to `N_CITIES`. Slot i is bits `[i*IDX_W +: IDX_W]` of each tour vector.
- R3: When `xo_en` is 1, child slots k and above hold, in order, the cities of parent B that are not among the first k cities of parent A. For example, with N_CITIES=8 and k=4, parent A 1,7,3,2,5,6,0,4 and parent B 0,2,4,1,6,5,7,3 give the child 1,7,3,2,0,4,6,5 (listed from slot 0).
- R4: Every published child is a permutation: each city index appears exactly once.
- R5: When `xo_en` is 0, the published child equals parent A for any `cut` and parent B.
- R6: k=0 yields a copy of parent B. A `cut` of `N_CITIES` or greater yields a copy of parent A.
- R7: `done` is high for exactly one cycle per run. `child` changes only in the cycle in which `done` is high, and holds its value otherwise.
- R8: `done` is seen no later than `N_CITIES+3` rising clock edges after the edge that samples `start`, counting that edge as the first.
- R9: A `start` pulse while a run is in progress is ignored. The run finishes with the inputs it captured, and no further `done` follows.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a run; sampled only when idle |
| xo_en | input | 1 | 1: apply crossover; 0: child copies parent A |
| cut | input | CUT_W | Crossover point k (values above N_CITIES are treated as N_CITIES) |
| par_a | input | N_CITIES*IDX_W | Parent A tour, slot i at bits [i*IDX_W +: IDX_W] |
| par_b | input | N_CITIES*IDX_W | Parent B tour, same packing |
| child | output | N_CITIES*IDX_W | Child tour, valid from the cycle done is high until the next done |
| done | output | 1 | One-cycle pulse when a new child is published |

## Verification
The bench uses random parent permutations with random cut points. These show whether the tail keeps parent B's order while skipping cities already placed, rather than copying parent B's slots. The example tour pair tells a skip-and-append tail apart from one that starts reading parent B at the cut position. Cut values of 0, exactly N_CITIES and above N_CITIES separate the two copy cases and the clamping from ordinary merges. Runs with crossover disabled, and a second start issued mid-run, show that the enable bit and the busy guard leave the captured parent A, and the run already in progress, unchanged.

// File: rtl/pxo_pkg.sv
package pxo_pkg;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_HEAD    = 2'd1,
        ST_SCAN    = 2'd2,
        ST_PUBLISH = 2'd3
    } pxo_state_e;

endpackage

// File: rtl/pxo_used_mask.sv
// Set of cities already placed in the child tour, one bit per city.
module pxo_used_mask #(
    parameter int N_CITIES = 8,
    parameter int IDX_W    = $clog2(N_CITIES)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                clr,
    input  logic                preset_en,
    input  logic [N_CITIES-1:0] preset,
    input  logic                set_en,
    input  logic [IDX_W-1:0]    set_idx,
    output logic [N_CITIES-1:0] used
);

    logic [N_CITIES-1:0] used_q;
    logic [N_CITIES-1:0] set_bit;

    assign set_bit = set_en ? (N_CITIES'(1) << set_idx) : '0;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            used_q <= '0;
        end else if (clr) begin
            used_q <= '0;
        end else if (preset_en) begin
            used_q <= preset;
        end else begin
            used_q <= used_q | set_bit;
        end
    end

    assign used = used_q;

endmodule

// File: rtl/pxo_fsm.sv
// Sequencer: capture, head load, tail scan, publish.
module pxo_fsm
    import pxo_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic       use_xo,
    input  logic       head_only,
    input  logic       scan_last,
    output pxo_state_e state,
    output logic       capture,
    output logic       head_step,
    output logic       scan_step,
    output logic       publish
);

    pxo_state_e state_q;
    pxo_state_e state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    if (start) state_d = ST_HEAD;
            ST_HEAD:    state_d = (!use_xo || head_only) ? ST_PUBLISH : ST_SCAN;
            ST_SCAN:    if (scan_last) state_d = ST_PUBLISH;
            ST_PUBLISH: state_d = ST_IDLE;
            default:    state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        capture   = 1'b0;
        head_step = 1'b0;
        scan_step = 1'b0;
        publish   = 1'b0;
        unique case (state_q)
            ST_IDLE:    capture   = start;
            ST_HEAD:    head_step = 1'b1;
            ST_SCAN:    scan_step = 1'b1;
            ST_PUBLISH: publish   = 1'b1;
            default:    ;
        endcase
    end

    assign state = state_q;

endmodule

// File: rtl/pxo_crossover.sv
// Permutation-preserving single-point crossover of two city tours.
module pxo_crossover
    import pxo_pkg::*;
#(
    parameter int N_CITIES = 8,
    parameter int IDX_W    = $clog2(N_CITIES),
    parameter int CUT_W    = $clog2(N_CITIES + 1)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      start,
    input  logic                      xo_en,
    input  logic [CUT_W-1:0]          cut,
    input  logic [N_CITIES*IDX_W-1:0] par_a,
    input  logic [N_CITIES*IDX_W-1:0] par_b,
    output logic [N_CITIES*IDX_W-1:0] child,
    output logic                      done
);

    localparam int TOUR_W = N_CITIES * IDX_W;
    localparam logic [CUT_W-1:0] CUT_FULL = CUT_W'(N_CITIES);
    localparam logic [CUT_W-1:0] WR_LAST  = CUT_W'(N_CITIES - 1);
    localparam logic [IDX_W-1:0] RD_LAST  = IDX_W'(N_CITIES - 1);

    // captured run inputs
    logic [TOUR_W-1:0] a_q;
    logic [TOUR_W-1:0] b_q;
    logic [CUT_W-1:0]  cut_q;
    logic              en_q;

    // scan pointers and tours
    logic [IDX_W-1:0]  rd_q;
    logic [CUT_W-1:0]  wr_q;
    logic [IDX_W-1:0]  work_q [N_CITIES];
    logic [TOUR_W-1:0] work_flat;
    logic [TOUR_W-1:0] child_q;
    logic              done_q;

    // control
    pxo_state_e        state;
    logic              capture;
    logic              head_step;
    logic              scan_step;
    logic              publish;
    logic              head_only;
    logic              scan_last;
    logic [N_CITIES-1:0] used;
    logic [N_CITIES-1:0] head_bits;
    logic [IDX_W-1:0]  city_b;
    logic              hit;
    logic              append;

    pxo_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .use_xo    (en_q),
        .head_only (head_only),
        .scan_last (scan_last),
        .state     (state),
        .capture   (capture),
        .head_step (head_step),
        .scan_step (scan_step),
        .publish   (publish)
    );

    pxo_used_mask #(
        .N_CITIES (N_CITIES),
        .IDX_W    (IDX_W)
    ) u_mask (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (capture),
        .preset_en (head_step),
        .preset    (head_bits),
        .set_en    (append),
        .set_idx   (city_b),
        .used      (used)
    );

    // input snapshot; cut is limited to the tour length
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            a_q   <= '0;
            b_q   <= '0;
            cut_q <= '0;
            en_q  <= 1'b0;
        end else if (capture) begin
            a_q   <= par_a;
            b_q   <= par_b;
            cut_q <= (cut > CUT_FULL) ? CUT_FULL : cut;
            en_q  <= xo_en;
        end
    end

    // cities placed ahead of the cut
    always_comb begin
        head_bits = '0;
        for (int i = 0; i < N_CITIES; i++) begin
            if (en_q && (CUT_W'(i) < cut_q)) begin
                head_bits[a_q[i*IDX_W +: IDX_W]] = 1'b1;
            end
        end
    end

    assign head_only = (cut_q == CUT_FULL);
    assign city_b    = b_q[int'(rd_q)*IDX_W +: IDX_W];
    assign hit       = used[city_b];
    assign append    = scan_step && !hit;
    assign scan_last = (rd_q == RD_LAST) || (append && (wr_q == WR_LAST));

    // scan pointers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_q <= '0;
            wr_q <= '0;
        end else if (head_step) begin
            rd_q <= '0;
            wr_q <= cut_q;
        end else if (scan_step) begin
            rd_q <= rd_q + 1'b1;
            if (append) begin
                wr_q <= wr_q + 1'b1;
            end
        end
    end

    // work tour: one register per slot
    for (genvar s = 0; s < N_CITIES; s++) begin : g_slot
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                work_q[s] <= '0;
            end else if (head_step) begin
                work_q[s] <= a_q[s*IDX_W +: IDX_W];
            end else if (append && (wr_q == CUT_W'(s))) begin
                work_q[s] <= city_b;
            end
        end
        assign work_flat[s*IDX_W +: IDX_W] = work_q[s];
    end

    // published result
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            child_q <= '0;
            done_q  <= 1'b0;
        end else begin
            done_q <= publish;
            if (publish) begin
                child_q <= work_flat;
            end
        end
    end

    assign child = child_q;
    assign done  = done_q;

endmodule

// File: rtl/pxo_checker.sv
// Port-level properties of the crossover block.
module pxo_checker #(
    parameter int N_CITIES = 8,
    parameter int IDX_W    = $clog2(N_CITIES),
    parameter int CUT_W    = $clog2(N_CITIES + 1)
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic                      start,
    input logic                      xo_en,
    input logic [CUT_W-1:0]          cut,
    input logic [N_CITIES*IDX_W-1:0] par_a,
    input logic [N_CITIES*IDX_W-1:0] par_b,
    input logic [N_CITIES*IDX_W-1:0] child,
    input logic                      done
);

    localparam int TOUR_W = N_CITIES * IDX_W;
    localparam int LAT_MAX = N_CITIES + 2;

    logic              busy_q;
    logic [15:0]       cnt_q;
    logic [TOUR_W-1:0] ra_q;
    logic [CUT_W-1:0]  rcut_q;
    logic              ren_q;
    logic [N_CITIES-1:0] seen;
    logic              head_ok;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            cnt_q  <= '0;
            ra_q   <= '0;
            rcut_q <= '0;
            ren_q  <= 1'b0;
        end else if (start && (!busy_q || done)) begin
            busy_q <= 1'b1;
            cnt_q  <= '0;
            ra_q   <= par_a;
            rcut_q <= (cut > CUT_W'(N_CITIES)) ? CUT_W'(N_CITIES) : cut;
            ren_q  <= xo_en;
        end else if (busy_q) begin
            if (done) busy_q <= 1'b0;
            cnt_q <= cnt_q + 16'd1;
        end
    end

    always_comb begin
        seen = '0;
        for (int i = 0; i < N_CITIES; i++) begin
            seen[child[i*IDX_W +: IDX_W]] = 1'b1;
        end
    end

    always_comb begin
        head_ok = 1'b1;
        for (int i = 0; i < N_CITIES; i++) begin
            if ((CUT_W'(i) < rcut_q) && (child[i*IDX_W +: IDX_W] != ra_q[i*IDX_W +: IDX_W])) begin
                head_ok = 1'b0;
            end
        end
    end

    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done); // R7
    AST_CHILD_HOLDS:    assert property (@(posedge clk) disable iff (!rst_n) !done |-> $stable(child)); // R7
    AST_CHILD_IS_PERM:  assert property (@(posedge clk) disable iff (!rst_n) done |-> (&seen)); // R4
    AST_HEAD_FROM_A:    assert property (@(posedge clk) disable iff (!rst_n) (done && ren_q) |-> head_ok); // R2
    AST_NO_XO_COPY:     assert property (@(posedge clk) disable iff (!rst_n) (done && !ren_q) |-> (child == ra_q)); // R5
    AST_LATENCY_BOUND:  assert property (@(posedge clk) disable iff (!rst_n) busy_q |-> (cnt_q <= 16'(LAT_MAX))); // R8
    AST_NO_STRAY_DONE:  assert property (@(posedge clk) disable iff (!rst_n) done |-> busy_q); // R9

endmodule

bind pxo_crossover pxo_checker #(
    .N_CITIES (N_CITIES),
    .IDX_W    (IDX_W),
    .CUT_W    (CUT_W)
) u_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .start (start),
    .xo_en (xo_en),
    .cut   (cut),
    .par_a (par_a),
    .par_b (par_b),
    .child (child),
    .done  (done)
);

// File: tb/pxo_crossover_bench.sv
`timescale 1ns/1ps
module pxo_crossover_bench;

    localparam int N  = 8;
    localparam int IW = 3;
    localparam int CW = 4;
    localparam int W  = N * IW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic          xo_en = 1'b0;
    logic [CW-1:0] cut = '0;
    logic [W-1:0]  par_a = '0;
    logic [W-1:0]  par_b = '0;
    logic [W-1:0]  child;
    logic          done;

    int checks = 0;
    int fails  = 0;

    always #10 clk = ~clk;

    pxo_crossover #(.N_CITIES(N), .IDX_W(IW), .CUT_W(CW)) u_pxo_crossover (
        .clk(clk), .rst_n(rst_n), .start(start), .xo_en(xo_en), .cut(cut),
        .par_a(par_a), .par_b(par_b), .child(child), .done(done)
    );

    task automatic check(input bit ok, input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [W-1:0] ref_child(input logic [W-1:0] a, input logic [W-1:0] b,
                                               input int k_in, input bit en);
        logic [W-1:0]  r;
        logic [N-1:0]  used;
        int k, w;
        r = a;
        if (!en) return a;
        k = (k_in > N) ? N : k_in;
        used = '0;
        for (int i = 0; i < k; i++) used[a[i*IW +: IW]] = 1'b1;
        w = k;
        for (int i = 0; i < N; i++) begin
            if (!used[b[i*IW +: IW]] && w < N) begin
                r[w*IW +: IW] = b[i*IW +: IW];
                used[b[i*IW +: IW]] = 1'b1;
                w++;
            end
        end
        return r;
    endfunction

    function automatic bit is_perm(input logic [W-1:0] t);
        logic [N-1:0] s;
        s = '0;
        for (int i = 0; i < N; i++) s[t[i*IW +: IW]] = 1'b1;
        return &s;
    endfunction

    function automatic logic [W-1:0] rand_perm();
        logic [IW-1:0] p [N];
        logic [IW-1:0] tmp;
        logic [W-1:0]  r;
        int j;
        for (int i = 0; i < N; i++) p[i] = IW'(i);
        for (int i = N - 1; i > 0; i--) begin
            j = $urandom_range(0, i);
            tmp = p[i]; p[i] = p[j]; p[j] = tmp;
        end
        for (int i = 0; i < N; i++) r[i*IW +: IW] = p[i];
        return r;
    endfunction

    // start a run at a falling edge, wait for done; returns child and edges elapsed
    task automatic run(input logic [W-1:0] a, input logic [W-1:0] b, input int k, input bit en,
                       output logic [W-1:0] res, output int edges);
        @(negedge clk);
        par_a = a; par_b = b; cut = CW'(k); xo_en = en; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        edges = 1;
        while (!done && edges < 40) begin
            @(negedge clk);
            edges++;
        end
        res = child;
    endtask

    task automatic full_check(input logic [W-1:0] a, input logic [W-1:0] b, input int k,
                              input bit en, input string req);
        logic [W-1:0] res, exp, hm;
        int edges, kk;
        run(a, b, k, en, res, edges);
        exp = ref_child(a, b, k, en);
        check(res == exp, req, res, exp);
        check(is_perm(res), "R4 permutation", res, exp);
        check(edges <= N + 3, "R8 latency", W'(edges), W'(N + 3));
        kk = (k > N) ? N : k;
        hm = '0;
        for (int i = 0; i < kk; i++) hm[i*IW +: IW] = '1;
        if (en) check((res & hm) == (a & hm), "R2 head slots", res & hm, a & hm);
        @(negedge clk);
        check(done == 1'b0, "R7 done single cycle", W'(done), '0);
        check(child == res, "R7 child held", child, res);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        logic [W-1:0] pa, pb, res, exp2;
        int edges, k;
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        check(child == '0, "R1 reset child", child, '0);
        check(done == 1'b0, "R1 reset done", W'(done), '0);
        rst_n = 1'b1;
        @(negedge clk);

        // R3 worked example, slot 0 in the low bits
        pa = {3'd4, 3'd0, 3'd6, 3'd5, 3'd2, 3'd3, 3'd7, 3'd1};
        pb = {3'd3, 3'd7, 3'd5, 3'd6, 3'd1, 3'd4, 3'd2, 3'd0};
        run(pa, pb, 4, 1'b1, res, edges);
        exp2 = {3'd5, 3'd6, 3'd4, 3'd0, 3'd2, 3'd3, 3'd7, 3'd1};
        check(res == exp2, "R3 example tour", res, exp2);

        // R6 boundaries
        full_check(pa, pb, 0, 1'b1, "R6 k=0 copies parent B");
        check(child == pb, "R6 k=0 equals B", child, pb);
        full_check(pa, pb, N, 1'b1, "R6 k=N copies parent A");
        check(child == pa, "R6 k=N equals A", child, pa);
        full_check(pa, pb, 13, 1'b1, "R6 k above N clamps");
        check(child == pa, "R6 clamp equals A", child, pa);

        // R5 crossover disabled
        full_check(pa, pb, 3, 1'b0, "R5 disabled copies A");
        check(child == pa, "R5 disabled equals A", child, pa);

        // R9 start during a run is ignored
        @(negedge clk);
        par_a = pa; par_b = pb; cut = CW'(2); xo_en = 1'b1; start = 1'b1;
        @(negedge clk);
        par_a = rand_perm(); par_b = rand_perm(); cut = CW'(5); xo_en = 1'b0; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        edges = 2;
        while (!done && edges < 40) begin
            @(negedge clk);
            edges++;
        end
        exp2 = ref_child(pa, pb, 2, 1'b1);
        check(child == exp2, "R9 busy start ignored", child, exp2);
        repeat (N + 4) begin
            @(negedge clk);
            check(done == 1'b0, "R9 no extra done", W'(done), '0);
        end

        // random merges, R3 and R5 by enable
        for (int n = 0; n < 60; n++) begin
            pa = rand_perm();
            pb = rand_perm();
            k = ($urandom_range(0, 9) == 0) ? int'($urandom_range(N, 15)) : int'($urandom_range(0, N));
            if ($urandom_range(0, 3) == 0) full_check(pa, pb, k, 1'b0, "R5 random disabled");
            else full_check(pa, pb, k, 1'b1, "R3 random merge");
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule